// File: doc/BRIEF.md
# Neuron Execution Unit with Sequential Booth Multiplier

This block carries out the arithmetic of one artificial neuron. Operand pairs arrive one command at a time, as a memory sequencer would supply them. The block multiplies each pair and adds the product into a saturating propagation sum. Other commands map the sum through a lookup-table activation function into the neuron's output state. They also form the output error against a target value and compute an updated synaptic weight.

There is no parallel multiplier. Every product comes from a sequential radix-2 Booth engine, which holds a multiplicand register, an accumulator/shifter pair and an add/subtract step. A small controller sequences the engine and the steps around it. The weight update runs the same engine twice in a row. It keeps the narrowed first product in an auxiliary register between the two runs. A command is accepted only while the unit is idle. Completion is marked by a one-cycle `done` pulse.

Command codes on `cmd_op`: 0 = multiply-accumulate, 1 = activate, 2 = error, 3 = weight update.

Top module: `neuron_exec_unit`

## Requirements
- R1: While reset is held, and after it is released, `busy` and `done` are 0 and `sum_out`, `state_out`, `error_out` and `weight_out` are all 0.
- R2: A multiply-accumulate command (code 0) replaces the sum with sum + `state_in`×`weight_in`. Both operands are signed 8-bit and the product is signed 16-bit. `done` rises in the 10th cycle after the accepting clock edge.
- R3: The sum is a signed 20-bit value that saturates at +524287 and at -524288 rather than wrapping.
- R4: The product is exact for every signed operand pair, including -128×-128, -128×127 and zero operands. The Booth engine takes exactly 8 step cycles per product.
- R5: An activate command (code 1) takes k, the top 6 bits of the sum read as a signed number in -32..31. It loads `state_out` with min(127, max(0, 64 + 4·k)) and clears the sum to 0. `done` rises 1 cycle after acceptance.
- R6: An error command (code 2) loads `error_out` with `target_in` − `state_out`, saturated to the signed 8-bit range. `done` rises 1 cycle after acceptance.
- R7: A weight update command (code 3) first forms m = sat8((`eta_in`×`error_out`) >>> 4). It then loads `weight_out` with sat8(`weight_in` + ((m×`state_in`) >>> 4)). Here >>> is an arithmetic shift and sat8 clamps to -128..127. `done` rises 20 cycles after acceptance.
- R8: `busy` is 1 from the cycle after acceptance until the cycle that carries `done`, where it is 0. `done` lasts exactly one cycle.
- R9: A command presented while `busy` is 1 is dropped. It does not change any result and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present; taken when the unit is idle |
| cmd_op | input | 2 | Command code (0 MAC, 1 activate, 2 error, 3 update) |
| state_in | input | 8 | Signed input state s_i |
| weight_in | input | 8 | Signed synaptic weight |
| target_in | input | 8 | Signed target output for the error command |
| eta_in | input | 8 | Signed learning rate for the weight update |
| busy | output | 1 | Unit is executing a command |
| done | output | 1 | One-cycle completion pulse |
| sum_out | output | 20 | Signed saturating propagation sum |
| state_out | output | 8 | Output state s_j |
| error_out | output | 8 | Output error e_j |
| weight_out | output | 8 | Updated weight from the last update command |

## Verification
Directed pairs exercise the Booth recoding edges: small positive values, the most negative operand in either position, both operands at their extremes, and zero. Each of these makes the engine take different add, subtract and skip paths. Long runs of the largest positive and largest negative products drive the sum into both saturation rails. The activate command that follows then shows that the rails map to the top and bottom table entries. Seeded random sequences mix short accumulation runs with activate, error and update commands, so that the chained use of `state_out` and `error_out` is compared against a reference model. A command injected during a running accumulation shows whether a dropped command leaves any trace.

// File: rtl/neu_pkg.sv
package neu_pkg;
  typedef enum logic [1:0] {
    OP_MAC = 2'd0,
    OP_ACT = 2'd1,
    OP_ERR = 2'd2,
    OP_UPD = 2'd3
  } neu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_M1GO  = 3'd1,
    ST_M1RUN = 3'd2,
    ST_M2GO  = 3'd3,
    ST_M2RUN = 3'd4,
    ST_FUNC  = 3'd5
  } neu_st_e;
endpackage

// File: rtl/neu_booth_mul.sv
module neu_booth_mul #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [W-1:0]          mcand,
  input  logic [W-1:0]          mplier,
  output logic                  busy,
  output logic signed [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    acc_q, acc_d;
  logic [W-1:0]  q_q, q_d;
  logic          qm1_q, qm1_d;
  logic [W-1:0]  m_q, m_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W:0]    alu_res;
  logic [W:0]    m_ext;

  assign m_ext = {m_q[W-1], m_q};
  assign busy  = (cnt_q != '0);
  assign prod  = $signed({acc_q[W-1:0], q_q});

  // shared add/subtract step chosen by the Booth pair
  always_comb begin
    case ({q_q[0], qm1_q})
      2'b01:   alu_res = acc_q + m_ext;
      2'b10:   alu_res = acc_q - m_ext;
      default: alu_res = acc_q;
    endcase
  end

  always_comb begin
    acc_d = acc_q;
    q_d   = q_q;
    qm1_d = qm1_q;
    m_d   = m_q;
    cnt_d = cnt_q;
    if (start) begin
      acc_d = '0;
      q_d   = mplier;
      qm1_d = 1'b0;
      m_d   = mcand;
      cnt_d = CW'(W);
    end else if (busy) begin
      acc_d = {alu_res[W], alu_res[W:1]};
      q_d   = {alu_res[0], q_q[W-1:1]};
      qm1_d = q_q[0];
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      q_q   <= '0;
      qm1_q <= 1'b0;
      m_q   <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      q_q   <= q_d;
      qm1_q <= qm1_d;
      m_q   <= m_d;
      cnt_q <= cnt_d;
    end
  end

  // checker: length of each run measured independently of cnt_q
  logic [CW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (start) run_len <= '0;
    else if (busy)  run_len <= run_len + 1'b1;
  end

  p_step_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == (CW+1)'(W)));
endmodule

// File: rtl/neu_act_lut.sv
module neu_act_lut #(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int SLOPE = 4
) (
  input  logic [AW-1:0] idx,
  output logic [DW-1:0] val
);
  localparam int DEPTH = 2 ** AW;
  localparam int MID   = 2 ** (DW - 2);
  localparam int TOPV  = 2 ** (DW - 1) - 1;

  function automatic logic [DW-1:0] entry(input int g);
    int x;
    int v;
    x = (g >= DEPTH / 2) ? g - DEPTH : g;
    v = MID + SLOPE * x;
    if (v < 0)    v = 0;
    if (v > TOPV) v = TOPV;
    return DW'(v);
  endfunction

  logic [DW-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign tbl[g] = entry(g);
  end

  assign val = tbl[idx];
endmodule

// File: rtl/neuron_exec_unit.sv
module neuron_exec_unit
  import neu_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SW        = 20,
  parameter int LUT_AW    = 6,
  parameter int ETA_SHIFT = 4,
  parameter int UPD_SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] state_in,
  input  logic [DW-1:0] weight_in,
  input  logic [DW-1:0] target_in,
  input  logic [DW-1:0] eta_in,
  output logic          busy,
  output logic          done,
  output logic [SW-1:0] sum_out,
  output logic [DW-1:0] state_out,
  output logic [DW-1:0] error_out,
  output logic [DW-1:0] weight_out
);
  localparam int PW = 2 * DW;
  localparam logic signed [PW:0] D_MAX = (PW+1)'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW:0] D_MIN = -(PW+1)'(2 ** (DW - 1));

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  function automatic logic [SW-1:0] sat_sum(input logic [SW:0] v);
    if (v[SW] != v[SW-1]) return v[SW] ? {1'b1, {(SW-1){1'b0}}} : {1'b0, {(SW-1){1'b1}}};
    return v[SW-1:0];
  endfunction

  function automatic logic [DW-1:0] sat_d(input logic signed [PW:0] v);
    if (v > D_MAX) return D_MAX[DW-1:0];
    if (v < D_MIN) return D_MIN[DW-1:0];
    return v[DW-1:0];
  endfunction

  neu_st_e st_q, st_d;
  neu_op_e op_q, op_d;
  logic [DW-1:0] si_q, si_d, w_q, w_d, tgt_q, tgt_d, eta_q, eta_d;
  logic [DW-1:0] sj_q, sj_d, ej_q, ej_d, wo_q, wo_d, mid_q, mid_d;
  logic [SW-1:0] sum_q, sum_d;
  logic          done_q, done_d;

  logic                 mul_go, mul_busy;
  logic [DW-1:0]        mul_a, mul_b;
  logic signed [PW-1:0] prod, prod_eta, prod_upd;
  logic [DW-1:0]        lut_val;
  logic [SW:0]          sum_wide;
  logic signed [PW:0]   diff_err, w_sum;

  neu_booth_mul #(.W(DW)) u_mul (
    .clk   (clk),
    .rst_n (rst_q),
    .start (mul_go),
    .mcand (mul_a),
    .mplier(mul_b),
    .busy  (mul_busy),
    .prod  (prod)
  );

  neu_act_lut #(.AW(LUT_AW), .DW(DW), .SLOPE(4)) u_lut (
    .idx(sum_q[SW-1 -: LUT_AW]),
    .val(lut_val)
  );

  assign prod_eta = prod >>> ETA_SHIFT;
  assign prod_upd = prod >>> UPD_SHIFT;
  assign sum_wide = {sum_q[SW-1], sum_q} + {{(SW+1-PW){prod[PW-1]}}, prod};
  assign diff_err = $signed({{(PW+1-DW){tgt_q[DW-1]}}, tgt_q})
                  - $signed({{(PW+1-DW){sj_q[DW-1]}}, sj_q});
  assign w_sum    = $signed({{(PW+1-DW){w_q[DW-1]}}, w_q})
                  + $signed({prod_upd[PW-1], prod_upd});

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    si_d   = si_q;
    w_d    = w_q;
    tgt_d  = tgt_q;
    eta_d  = eta_q;
    sj_d   = sj_q;
    ej_d   = ej_q;
    wo_d   = wo_q;
    mid_d  = mid_q;
    sum_d  = sum_q;
    done_d = 1'b0;
    mul_go = 1'b0;
    mul_a  = si_q;
    mul_b  = w_q;
    case (st_q)
      ST_IDLE: if (cmd_valid) begin
        op_d  = neu_op_e'(cmd_op);
        si_d  = state_in;
        w_d   = weight_in;
        tgt_d = target_in;
        eta_d = eta_in;
        st_d  = (cmd_op == OP_MAC || cmd_op == OP_UPD) ? ST_M1GO : ST_FUNC;
      end
      ST_M1GO: begin
        mul_go = 1'b1;
        if (op_q == OP_UPD) begin
          mul_a = eta_q;
          mul_b = ej_q;
        end
        st_d = ST_M1RUN;
      end
      ST_M1RUN: if (!mul_busy) begin
        if (op_q == OP_MAC) begin
          sum_d  = sat_sum(sum_wide);
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          mid_d = sat_d($signed({prod_eta[PW-1], prod_eta}));
          st_d  = ST_M2GO;
        end
      end
      ST_M2GO: begin
        mul_go = 1'b1;
        mul_a  = mid_q;
        mul_b  = si_q;
        st_d   = ST_M2RUN;
      end
      ST_M2RUN: if (!mul_busy) begin
        wo_d   = sat_d(w_sum);
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_FUNC: begin
        if (op_q == OP_ACT) begin
          sj_d  = lut_val;
          sum_d = '0;
        end else begin
          ej_d = sat_d(diff_err);
        end
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_MAC;
      si_q   <= '0;
      w_q    <= '0;
      tgt_q  <= '0;
      eta_q  <= '0;
      sj_q   <= '0;
      ej_q   <= '0;
      wo_q   <= '0;
      mid_q  <= '0;
      sum_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      si_q   <= si_d;
      w_q    <= w_d;
      tgt_q  <= tgt_d;
      eta_q  <= eta_d;
      sj_q   <= sj_d;
      ej_q   <= ej_d;
      wo_q   <= wo_d;
      mid_q  <= mid_d;
      sum_q  <= sum_d;
      done_q <= done_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign sum_out    = sum_q;
  assign state_out  = sj_q;
  assign error_out  = ej_q;
  assign weight_out = wo_q;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done);
  p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> !busy);
  p_sum_only_on_done_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(sum_q) |-> done);
  p_act_clears_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_FUNC && op_q == OP_ACT) |=> (sum_q == '0));
  p_state_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !sj_q[DW-1]);
endmodule

// File: tb/sim_neuron_exec_unit.sv
module sim_neuron_exec_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] state_in = 8'd0, weight_in = 8'd0, target_in = 8'd0, eta_in = 8'd0;
  logic       busy, done;
  logic [19:0] sum_out;
  logic [7:0] state_out, error_out, weight_out;

  int n_cmp = 0;
  int n_bad = 0;
  int m_sum = 0, m_sj = 0, m_ej = 0, m_wo = 0;

  always #10 clk = ~clk;

  neuron_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .state_in(state_in), .weight_in(weight_in), .target_in(target_in), .eta_in(eta_in),
    .busy(busy), .done(done), .sum_out(sum_out), .state_out(state_out),
    .error_out(error_out), .weight_out(weight_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int sat20(input int v);
    if (v > 524287) return 524287;
    if (v < -524288) return -524288;
    return v;
  endfunction

  function automatic int lut(input int s);
    int k, v;
    k = s >>> 14;
    v = 64 + 4 * k;
    if (v < 0) v = 0;
    if (v > 127) v = 127;
    return v;
  endfunction

  task automatic run_cmd(input int op, input int si, input int w, input int tg, input int et,
                         output int lat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op);
    state_in = 8'(si); weight_in = 8'(w); target_in = 8'(tg); eta_in = 8'(et);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 busy after accept", int'(busy), 1);
    lat = 0;
    while (lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
    end
    chk("R8 busy low at done", int'(busy), 0);
  endtask

  task automatic do_mac(input int si, input int w, input string tag);
    int lat;
    run_cmd(0, si, w, 0, 0, lat);
    m_sum = sat20(m_sum + si * w);
    chk({tag, " latency"}, lat, 10);
    chk(tag, $signed(sum_out), m_sum);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
  endtask

  task automatic do_act();
    int lat;
    run_cmd(1, 0, 0, 0, 0, lat);
    m_sj = lut(m_sum);
    m_sum = 0;
    chk("R5 latency", lat, 1);
    chk("R5 state", int'(state_out), m_sj);
    chk("R5 sum cleared", $signed(sum_out), 0);
  endtask

  task automatic do_err(input int tg);
    int lat;
    run_cmd(2, 0, 0, tg, 0, lat);
    m_ej = sat8(tg - m_sj);
    chk("R6 latency", lat, 1);
    chk("R6 error", $signed(error_out), m_ej);
  endtask

  task automatic do_upd(input int si, input int w, input int et);
    int lat, mid;
    run_cmd(3, si, w, 0, et, lat);
    mid = sat8((et * m_ej) >>> 4);
    m_wo = sat8(w + ((mid * si) >>> 4));
    chk("R7 latency", lat, 20);
    chk("R7 weight", $signed(weight_out), m_wo);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 sum in reset", int'(sum_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 sum", int'(sum_out), 0);
    chk("R1 state", int'(state_out), 0);
    chk("R1 error", int'(error_out), 0);
    chk("R1 weight", int'(weight_out), 0);

    // R2 / R4 directed Booth corners
    do_mac(3, 4, "R2 small");
    do_mac(-128, -128, "R4 minmin");
    do_mac(-128, 127, "R4 min max");
    do_mac(127, -128, "R4 max min");
    do_mac(0, -77, "R4 zero");
    do_mac(-1, -1, "R4 ones");
    do_act();
    do_err(100);
    do_upd(50, -20, 90);
    do_err(-128);
    do_upd(-128, 127, -128);

    // R3 positive and negative saturation
    for (int i = 0; i < 34; i++) do_mac(127, 127, "R3 pos");
    chk("R3 pos rail", $signed(sum_out), 524287);
    do_act();
    chk("R5 top entry", int'(state_out), 127);
    for (int i = 0; i < 34; i++) do_mac(-128, 127, "R3 neg");
    chk("R3 neg rail", $signed(sum_out), -524288);
    do_act();
    chk("R5 bottom entry", int'(state_out), 0);

    // R9 command during busy is dropped
    do_mac(20, 30, "R2 pre");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; state_in = 8'd10; weight_in = 8'd10;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    m_sum = sat20(m_sum + 100);
    chk("R9 sum kept", $signed(sum_out), m_sum);
    lat = 0;
    repeat (5) begin @(negedge clk); if (done) lat++; end
    chk("R9 no extra done", lat, 0);
    chk("R9 sum after", $signed(sum_out), m_sum);
    chk("R9 state kept", int'(state_out), m_sj);

    // seeded random mixes
    for (int r = 0; r < 40; r++) begin
      int n;
      n = 1 + int'($urandom_range(5));
      for (int k = 0; k < n; k++)
        do_mac($signed(8'($urandom)), $signed(8'($urandom)), "R2 random");
      do_act();
      do_err($signed(8'($urandom)));
      do_upd($signed(8'($urandom)), $signed(8'($urandom)), $signed(8'($urandom)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule